// File: doc/BRIEF.md
# Spectral Perturbation Test-Stream Generator

This block turns one stored spectral profile into many different pseudo-random test bit-streams that share that profile. Software or an upstream engine loads N signed Walsh coefficients, each with a flag that marks it as essential or as noise. A generate pulse then starts one pass. In each pass the essential coefficients are used exactly as stored. Each noise coefficient keeps its stored magnitude but takes a random sign drawn from an internal 16-bit LFSR. The modified vector is run through an in-place Walsh–Hadamard butterfly network. The sign of each result becomes one output bit, and the bits are shifted out serially in time order.

Each pass advances the LFSR, so back-to-back passes give a family of distinct sequences from one profile. Reloading the seed replays a family. The pass is fixed in length: N cycles to build the perturbed vector, log2(N) cycles of butterflies, N cycles of serial output, and then a one-cycle done pulse.

Top module: `spectral_stream_gen`

## Requirements
- R1: After reset, `busy`, `bit_valid`, `seq_done` and `bit_out` are all 0, every stored coefficient is 0, every coefficient is marked noise, and the LFSR holds 16'hACE1.
- R2: While idle, `load_en` stores `load_coef` (signed, CW bits) and `load_ess` (1 = essential, 0 = noise) at index `load_idx`. The stored values are used by every following pass.
- R3: An essential coefficient enters the transform with its stored signed value in every pass.
- R4: Coefficients are processed in index order 0..N-1, and the LFSR steps once per coefficient whether it is essential or noise. A noise coefficient takes the value -|c| when bit 0 of the LFSR state before that step is 1, and +|c| when it is 0. This holds for c = -2^(CW-1).
- R5: The LFSR step is s' = {s[14:0], s[15]^s[13]^s[12]^s[10]}. While idle, `seed_load` sets s to `seed_val`, but a zero seed is replaced by 16'hACE1. The state is never zero.
- R6: Output bit j (0 ≤ j < N) is 1 when y[j] = Σ_i c'[i]·(-1)^popcount(i AND j) is ≥ 0, and 0 otherwise. A result of exactly zero gives 1.
- R7: After a pass starts, bits j = 0..N-1 appear on `bit_out` on N consecutive cycles with `bit_valid` high. `bit_out` is 0 whenever `bit_valid` is low.
- R8: `seq_done` is high for exactly one cycle: the cycle after bit N-1, in which `bit_valid` is low.
- R9: While `busy` is high, `gen`, `seed_load` and `load_en` have no effect. The current pass is unchanged, no second pass follows, and the next pass uses the old coefficients and the continued LFSR.
- R10: Passes started without reseeding continue the LFSR from where the previous pass left it, so each pass draws fresh signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Store a coefficient and its flag (idle only) |
| load_idx | input | log2(N) | Coefficient index to store |
| load_coef | input | CW | Signed coefficient value |
| load_ess | input | 1 | 1 = essential, 0 = noise |
| seed_load | input | 1 | Load the LFSR seed (idle only) |
| seed_val | input | 16 | Seed value; zero is replaced by 16'hACE1 |
| gen | input | 1 | Start one generation pass (idle only) |
| bit_out | output | 1 | Serial output bit |
| bit_valid | output | 1 | `bit_out` holds a stream bit |
| seq_done | output | 1 | One-cycle pulse after the last bit |
| busy | output | 1 | A pass is in progress |

## Verification
The bench targets the following corner cases:

- **Zero transform result.** An all-zero profile yields results that are exactly zero. A design that took the raw sign bit the wrong way would emit all zeros instead of all ones.
- **Most negative noise coefficient.** A noise coefficient equal to -128 checks the magnitude path. A design that negated it in CW bits would wrap and flip output bits.
- **Zero seed.** Loading a zero seed must fall back to the default. A design without that substitution would lock up with constant signs.
- **Single-coefficient profiles.** These check the Hadamard row order. A swapped butterfly sign would show up as a mirrored alternating pattern.
- **Inputs during a pass.** Start, seed and load pulses are applied mid-pass. A design that honoured any of them would corrupt the running pass, start an extra pass, or shift the signs of the following pass.

// File: rtl/spg_pkg.sv
package spg_pkg;

   localparam logic [15:0] SPG_SEED_DEFAULT = 16'hACE1;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PREP  = 2'd1,
      ST_XFORM = 2'd2,
      ST_EMIT  = 2'd3
   } spg_state_e;

   function automatic logic [15:0] spg_lfsr_next(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

endpackage

// File: rtl/spg_lfsr.sv
module spg_lfsr
   import spg_pkg::*;
#(
   parameter logic [15:0] RESET_VAL = SPG_SEED_DEFAULT
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        seed_we,
   input  logic [15:0] seed_in,
   input  logic        step,
   output logic [15:0] state_o
);

   if (RESET_VAL == 16'd0) begin : g_bad_reset_val
      $error("spg_lfsr: RESET_VAL must be nonzero");
   end

   logic [15:0] s_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_q <= RESET_VAL;
      end else if (seed_we) begin
         s_q <= (seed_in == 16'd0) ? RESET_VAL : seed_in;
      end else if (step) begin
         s_q <= spg_lfsr_next(s_q);
      end
   end

   assign state_o = s_q;

   // R5: the register never reaches the lock-up state
   assert_state_nonzero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      s_q != 16'd0);

   // R5: a zero seed falls back to the default value
   assert_zero_seed_default_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (seed_we && seed_in == 16'd0) |=> (s_q == RESET_VAL));

endmodule

// File: rtl/spg_perturb.sv
module spg_perturb #(
   parameter int CW = 8,
   parameter int W  = 13
) (
   input  logic signed [CW-1:0] coef_in,
   input  logic                 essential,
   input  logic                 neg_sign,
   output logic signed [W-1:0]  value_o
);

   if (W <= CW) begin : g_bad_width
      $error("spg_perturb: W must exceed CW so the magnitude of the most negative value fits");
   end

   logic signed [W-1:0] ext;
   logic signed [W-1:0] mag;

   always_comb begin
      ext = W'(coef_in);
      mag = (ext < 0) ? -ext : ext;
      if (essential) begin
         value_o = ext;
      end else if (neg_sign) begin
         value_o = -mag;
      end else begin
         value_o = mag;
      end
   end

endmodule

// File: rtl/spg_wht_net.sv
module spg_wht_net #(
   parameter int N     = 16,
   parameter int W     = 13,
   parameter int LOG2N = $clog2(N),
   parameter int SW    = (LOG2N > 1) ? $clog2(LOG2N) : 1
) (
   input  logic signed [W-1:0] vec_in  [N],
   input  logic [SW-1:0]       stage,
   output logic signed [W-1:0] vec_out [N]
);

   if ((1 << LOG2N) != N || N < 2) begin : g_bad_n
      $error("spg_wht_net: N must be a power of two and at least 2");
   end

   logic signed [W-1:0] stage_res [LOG2N][N];

   for (genvar s = 0; s < LOG2N; s++) begin : g_stage
      localparam int SPAN = 1 << s;
      for (genvar i = 0; i < N; i++) begin : g_elem
         if ((i & SPAN) == 0) begin : g_top
            assign stage_res[s][i] = vec_in[i] + vec_in[i + SPAN];
         end else begin : g_bot
            assign stage_res[s][i] = vec_in[i - SPAN] - vec_in[i];
         end
      end
   end

   always_comb begin
      vec_out = stage_res[0];
      for (int s = 1; s < LOG2N; s++) begin
         if (stage == SW'(s)) begin
            vec_out = stage_res[s];
         end
      end
   end

endmodule

// File: rtl/spectral_stream_gen.sv
module spectral_stream_gen
   import spg_pkg::*;
#(
   parameter int N  = 16,
   parameter int CW = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_en,
   input  logic [$clog2(N)-1:0]     load_idx,
   input  logic signed [CW-1:0]     load_coef,
   input  logic                     load_ess,
   input  logic                     seed_load,
   input  logic [15:0]              seed_val,
   input  logic                     gen,
   output logic                     bit_out,
   output logic                     bit_valid,
   output logic                     seq_done,
   output logic                     busy
);

   localparam int LOG2N = $clog2(N);
   localparam int IW    = LOG2N;
   localparam int W     = CW + LOG2N + 1;
   localparam int SW    = (LOG2N > 1) ? $clog2(LOG2N) : 1;
   localparam logic [IW-1:0] LAST_IDX   = IW'(N - 1);
   localparam logic [SW-1:0] LAST_STAGE = SW'(LOG2N - 1);

   if ((1 << LOG2N) != N || N < 2) begin : g_bad_n
      $error("spectral_stream_gen: N must be a power of two and at least 2");
   end
   if (CW < 2) begin : g_bad_cw
      $error("spectral_stream_gen: CW must be at least 2");
   end

   spg_state_e          st;
   logic [IW-1:0]       idx;
   logic [SW-1:0]       stage;
   logic                done_q;
   logic signed [CW-1:0] coef_mem [N];
   logic [N-1:0]        ess_mem;
   logic signed [W-1:0] work     [N];
   logic signed [W-1:0] net_out  [N];
   logic signed [W-1:0] prep_val;
   logic signed [W-1:0] coef_ext;
   logic [15:0]         lfsr_state;
   logic                idle;

   assign idle     = (st == ST_IDLE);
   assign coef_ext = W'(coef_mem[idx]);

   // coefficient store, writable only between passes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            coef_mem[i] <= '0;
         end
         ess_mem <= '0;
      end else if (load_en && idle) begin
         coef_mem[load_idx] <= load_coef;
         ess_mem[load_idx]  <= load_ess;
      end
   end

   spg_lfsr u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .seed_we (seed_load && idle),
      .seed_in (seed_val),
      .step    (st == ST_PREP),
      .state_o (lfsr_state)
   );

   spg_perturb #(.CW(CW), .W(W)) u_perturb (
      .coef_in   (coef_mem[idx]),
      .essential (ess_mem[idx]),
      .neg_sign  (lfsr_state[0]),
      .value_o   (prep_val)
   );

   spg_wht_net #(.N(N), .W(W), .LOG2N(LOG2N), .SW(SW)) u_net (
      .vec_in  (work),
      .stage   (stage),
      .vec_out (net_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         idx    <= '0;
         stage  <= '0;
         done_q <= 1'b0;
         for (int i = 0; i < N; i++) begin
            work[i] <= '0;
         end
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (gen) begin
                  st  <= ST_PREP;
                  idx <= '0;
               end
            end
            ST_PREP: begin
               work[idx] <= prep_val;
               idx       <= idx + 1'b1;
               if (idx == LAST_IDX) begin
                  st    <= ST_XFORM;
                  stage <= '0;
               end
            end
            ST_XFORM: begin
               work <= net_out;
               if (stage == LAST_STAGE) begin
                  st  <= ST_EMIT;
                  idx <= '0;
               end else begin
                  stage <= stage + 1'b1;
               end
            end
            ST_EMIT: begin
               idx <= idx + 1'b1;
               if (idx == LAST_IDX) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign bit_valid = (st == ST_EMIT);
   assign bit_out   = bit_valid & ~work[idx][W-1];
   assign seq_done  = done_q;
   assign busy      = !idle;

   // R3: an essential coefficient is written with its stored value
   assert_essential_kept_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PREP && ess_mem[idx]) |=> (work[$past(idx)] == $past(coef_ext)));

   // R4: a noise coefficient keeps its magnitude and only its sign may change
   assert_noise_magnitude_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PREP && !ess_mem[idx]) |=>
         ((work[$past(idx)] == $past(coef_ext)) || (work[$past(idx)] == -$past(coef_ext))));

   // R7: output bits after the first are back to back
   assert_emit_contiguous_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && idx != '0) |-> $past(bit_valid));

   // R8: the done pulse follows the last bit and never overlaps a bit
   assert_done_after_last_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> ($past(bit_valid) && !bit_valid));

   // R8: the done pulse lasts one cycle
   assert_done_single_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done);

   // R9: seed and coefficient store are frozen while the stream is emitted
   assert_frozen_when_busy_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EMIT) |=> ($stable(lfsr_state) && $stable(ess_mem)));

endmodule

// File: tb/spectral_stream_gen_bench.sv
module spectral_stream_gen_bench;

   localparam int N  = 16;
   localparam int CW = 8;
   localparam int IW = $clog2(N);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 load_en = 1'b0;
   logic [IW-1:0]        load_idx = '0;
   logic signed [CW-1:0] load_coef = '0;
   logic                 load_ess = 1'b0;
   logic                 seed_load = 1'b0;
   logic [15:0]          seed_val = '0;
   logic                 gen = 1'b0;
   logic                 bit_out, bit_valid, seq_done, busy;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   int        m_coef [N];
   bit        m_ess  [N];
   bit [15:0] m_lfsr;
   bit        exp_bits [N];

   always #5 clk = ~clk;

   spectral_stream_gen #(.N(N), .CW(CW)) u_spectral_stream_gen (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
      .load_coef(load_coef), .load_ess(load_ess), .seed_load(seed_load),
      .seed_val(seed_val), .gen(gen), .bit_out(bit_out), .bit_valid(bit_valid),
      .seq_done(seq_done), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
         end
      end
   end

   function automatic bit [15:0] ref_step(input bit [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   // R4/R6 reference: perturb, then direct Hadamard product and sign
   function automatic void predict();
      int cp [N];
      for (int i = 0; i < N; i++) begin
         int v = m_coef[i];
         if (!m_ess[i]) begin
            int mag = (v < 0) ? -v : v;
            v = m_lfsr[0] ? -mag : mag;
         end
         cp[i] = v;
         m_lfsr = ref_step(m_lfsr);
      end
      for (int j = 0; j < N; j++) begin
         int y = 0;
         for (int i = 0; i < N; i++) begin
            y += ($countones(i & j) % 2 == 1) ? -cp[i] : cp[i];
         end
         exp_bits[j] = (y >= 0);
      end
   endfunction

   task automatic load_one(input int idx, input int coef, input bit ess);
      @(negedge clk);
      load_en = 1'b1; load_idx = IW'(idx); load_coef = CW'(coef); load_ess = ess;
      @(negedge clk);
      load_en = 1'b0;
      m_coef[idx] = coef;
      m_ess[idx]  = ess;
   endtask

   task automatic load_seed(input bit [15:0] s);
      @(negedge clk);
      seed_load = 1'b1; seed_val = s;
      @(negedge clk);
      seed_load = 1'b0;
      m_lfsr = (s == 16'd0) ? 16'hACE1 : s;
   endtask

   // one full pass; when inject is set, start/seed/load pulses hit mid-pass
   task automatic run_pass(input string req, input bit inject);
      int got = 0;
      int guard = 0;
      predict();
      @(negedge clk);
      gen = 1'b1;
      @(negedge clk);
      gen = 1'b0;
      while (got < N && guard < 200) begin
         @(negedge clk);
         guard++;
         load_en = 1'b0; seed_load = 1'b0; gen = 1'b0;
         if (bit_valid) begin
            check(bit_out == exp_bits[got], $sformatf("%s bit %0d", req, got),
                  int'(bit_out), int'(exp_bits[got]));
            if (inject && got == 3) begin
               gen = 1'b1; seed_load = 1'b1; seed_val = 16'h1234;
               load_en = 1'b1; load_idx = '0; load_coef = 8'sd77; load_ess = 1'b1;
            end
            got++;
         end else if (got > 0) begin
            check(1'b0, "R7 gap in stream", got, N);
         end
      end
      check(got == N, "R7 bit count", got, N);
      @(negedge clk);
      load_en = 1'b0; seed_load = 1'b0; gen = 1'b0;
      check(seq_done == 1'b1 && bit_valid == 1'b0, "R8 done after last bit",
            int'({seq_done, bit_valid}), 2);
      @(negedge clk);
      check(seq_done == 1'b0, "R8 done one cycle", int'(seq_done), 0);
   endtask

   initial begin
      void'($urandom(32'h5EC7A11));
      m_lfsr = 16'hACE1;
      for (int i = 0; i < N; i++) begin
         m_coef[i] = 0;
         m_ess[i]  = 1'b0;
      end
      repeat (3) @(negedge clk);
      check({busy, bit_valid, seq_done, bit_out} == 4'b0000, "R1 reset outputs",
            int'({busy, bit_valid, seq_done, bit_out}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, bit_valid, seq_done} == 3'b000, "R1 idle after reset",
            int'({busy, bit_valid, seq_done}), 0);

      // R1 R6: reset profile is all zero, so every result is zero -> all ones
      run_pass("R1 R6 zero profile", 1'b0);
      for (int j = 0; j < N; j++) begin
         check(exp_bits[j] == 1'b1, "R6 zero maps to one", int'(exp_bits[j]), 1);
      end

      // R6: single essential coefficient at index 1 gives alternating row
      for (int i = 0; i < N; i++) load_one(i, 0, 1'b1);
      load_one(1, -3, 1'b1);
      run_pass("R2 R3 R6 single row", 1'b0);
      for (int j = 0; j < N; j++) begin
         check(exp_bits[j] == j[0], "R6 row order", int'(exp_bits[j]), j % 2);
      end

      // R4: most negative noise coefficient dominating the profile
      load_one(1, 0, 1'b1);
      load_one(0, -128, 1'b0);
      load_one(5, 3, 1'b1);
      run_pass("R4 most negative noise", 1'b0);
      run_pass("R4 R10 continued signs", 1'b0);

      // R5: zero seed falls back to the default
      load_seed(16'd0);
      run_pass("R5 zero seed", 1'b0);

      // R9: pulses during a pass are ignored
      for (int i = 0; i < N; i++) load_one(i, int'($urandom_range(0, 255)) - 128, 1'(i % 3 == 0));
      load_seed(16'hBEEF);
      run_pass("R9 inject mid pass", 1'b1);
      repeat (2 * N + 10) begin
         @(negedge clk);
         check(!busy && !bit_valid, "R9 no extra pass", int'({busy, bit_valid}), 0);
      end
      run_pass("R9 R10 old profile next pass", 1'b0);

      // R2 R3 R4 R5 R6 R10: random profiles, seeds and back-to-back passes
      for (int r = 0; r < 12; r++) begin
         for (int i = 0; i < N; i++) begin
            load_one(i, int'($urandom_range(0, 255)) - 128, 1'($urandom_range(0, 1)));
         end
         if (r % 3 == 0) load_seed(16'($urandom_range(0, 65535)));
         run_pass("R3 R4 R6 random", 1'b0);
         run_pass("R10 random repeat", 1'b0);
      end

      finish_run();
   end

endmodule